// File: doc/BRIEF.md
# Sleep Mode Clock Controller

This block is the power-management controller of a small microcontroller. Firmware picks one of five sleep modes in a mode field, sets a sleep-enable bit and then issues the sleep instruction, which reaches the block as a one-cycle strobe. The block then stops the clock domains and oscillators that the chosen mode does not need. It watches five classes of interrupt request and returns to active operation when one that the mode allows arrives.

The five modes differ in what keeps running and in what can wake the device. Idle stops only the processor and the program-memory clocks, and any interrupt wakes it. The deep modes also stop the peripheral clock and accept only asynchronous sources. Two of the deep modes stop the system oscillator, so the processor clock comes back only after a counted oscillator-ready delay. The other two keep the oscillator running and resume on the next cycle. When the block wakes, a one-cycle pulse carries a one-hot code of the source that caused the wake. Reset always returns the block to active operation.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: During and after reset the block is active. cpu_clk_en, nvm_clk_en, per_clk_en and sys_osc_en are 1. rtc_clk_en and rtc_osc_en equal rtc_enable. asleep, wake_pulse and wake_src are 0.
- R2: In active operation, a sleep_strobe with sleep_en=1 makes asleep go high in the next cycle, and the block samples mode_sel at that strobe. Later changes of mode_sel have no effect until the next entry. A strobe with sleep_en=0 is ignored and the block stays active.
- R3: mode_sel encodings are 0 Idle, 2 Power-down, 3 Power-save, 6 Standby and 7 Extended Standby. The reserved codes 1, 4 and 5 behave exactly as Idle.
- R4: In Idle, cpu_clk_en and nvm_clk_en are 0. per_clk_en and sys_osc_en are 1, and the two RTC enables follow rtc_enable. Any irq bit wakes the block.
- R5: In Power-down all six enables are 0. Only irq[0] (asynchronous port) and irq[1] (two-wire address match) wake the block.
- R6: In Power-save all enables are 0 except rtc_clk_en and rtc_osc_en, which follow rtc_enable. irq[0], irq[1], irq[2] (RTC overflow) and irq[3] (RTC compare) wake the block.
- R7: In Standby only sys_osc_en is 1. Only irq[0] and irq[1] wake the block.
- R8: In Extended Standby, sys_osc_en is 1 and the RTC enables follow rtc_enable. The processor, memory and peripheral clocks are 0. The wake sources are the same as in Power-save.
- R9: On a wake from Power-down or Power-save, sys_osc_en is 1 from the cycle after the wake edge. The processor, memory and peripheral clocks return exactly OSC_READY_CYCLES cycles after that edge.
- R10: On a wake from Idle, Standby or Extended Standby, all active enables return in the cycle after the wake edge, which is the same cycle as wake_pulse.
- R11: wake_pulse is high for one cycle, in the cycle after the wake edge. During that cycle wake_src is the one-hot code of the lowest-numbered qualifying irq bit, and at all other times it is 0. The bit assignment is 0 port, 1 two-wire match, 2 RTC overflow, 3 RTC compare and 4 any other interrupt.
- R12: An irq bit that the current mode does not allow is ignored. The block stays asleep and the enables do not change.
- R13: Reset asserted during sleep returns the block at once to the active state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (always running) |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 3 | Sleep mode field |
| sleep_en | input | 1 | Sleep-enable bit |
| sleep_strobe | input | 1 | One-cycle sleep instruction strobe |
| rtc_enable | input | 1 | RTC is enabled by software |
| irq | input | 5 | Classified interrupt requests |
| cpu_clk_en | output | 1 | Processor clock enable |
| nvm_clk_en | output | 1 | Program-memory clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| rtc_clk_en | output | 1 | RTC clock enable |
| sys_osc_en | output | 1 | System oscillator enable |
| rtc_osc_en | output | 1 | RTC oscillator enable |
| asleep | output | 1 | Execution halted (sleeping or warming up) |
| wake_pulse | output | 1 | One-cycle wake event |
| wake_src | output | 5 | One-hot wake cause, valid with wake_pulse |

## Verification
A sleep strobe and a qualifying interrupt can arrive in the same cycle. The bench provokes this by raising the strobe and an irq bit on the same clock in Idle. It expects one cycle of asleep, then wake_pulse with the correct source code, and then active enables, so the early interrupt must neither block entry nor be lost. Two qualifying sources can also be raised together, and the bench then checks that wake_src names only the lower-numbered one.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
   localparam int MODE_W  = 3;
   localparam int WAKE_N  = 5;

   localparam logic [MODE_W-1:0] MODE_IDLE  = 3'd0;
   localparam logic [MODE_W-1:0] MODE_PDOWN = 3'd2;
   localparam logic [MODE_W-1:0] MODE_PSAVE = 3'd3;
   localparam logic [MODE_W-1:0] MODE_STBY  = 3'd6;
   localparam logic [MODE_W-1:0] MODE_XSTBY = 3'd7;

   // wake source classes, index = priority (lowest wins)
   localparam int SRC_PORT = 0;
   localparam int SRC_TWI  = 1;
   localparam int SRC_OVF  = 2;
   localparam int SRC_CMP  = 3;
   localparam int SRC_ANY  = 4;

   typedef enum logic [1:0] {
      ST_ACTIVE = 2'd0,
      ST_SLEEP  = 2'd1,
      ST_WARM   = 2'd2
   } pm_state_t;

   typedef struct packed {
      logic cpu;
      logic nvm;
      logic per;
      logic rtc;
      logic sys_osc;
      logic rtc_osc;
   } dom_t;
endpackage

// File: rtl/sleep_mode_decode.sv
module sleep_mode_decode
   import sleep_pkg::*;
(
   input  logic [MODE_W-1:0] mode,
   input  logic              rtc_enable,
   output dom_t              prof,
   output logic [WAKE_N-1:0] wake_mask,
   output logic              fast
);
   localparam logic [WAKE_N-1:0] ASYNC_MASK = (WAKE_N'(1) << SRC_PORT) | (WAKE_N'(1) << SRC_TWI);
   localparam logic [WAKE_N-1:0] RTC_MASK   = ASYNC_MASK | (WAKE_N'(1) << SRC_OVF) | (WAKE_N'(1) << SRC_CMP);

   always_comb begin
      prof      = '0;
      wake_mask = '1;
      fast      = 1'b1;
      case (mode)
         MODE_PDOWN: begin
            wake_mask = ASYNC_MASK;
            fast      = 1'b0;
         end
         MODE_PSAVE: begin
            prof.rtc     = rtc_enable;
            prof.rtc_osc = rtc_enable;
            wake_mask    = RTC_MASK;
            fast         = 1'b0;
         end
         MODE_STBY: begin
            prof.sys_osc = 1'b1;
            wake_mask    = ASYNC_MASK;
         end
         MODE_XSTBY: begin
            prof.sys_osc = 1'b1;
            prof.rtc     = rtc_enable;
            prof.rtc_osc = rtc_enable;
            wake_mask    = RTC_MASK;
         end
         default: begin // Idle and reserved codes
            prof.per     = 1'b1;
            prof.sys_osc = 1'b1;
            prof.rtc     = rtc_enable;
            prof.rtc_osc = rtc_enable;
         end
      endcase
   end

   always_comb begin
      if (!fast) assert_slow_stops_osc_R9: assert (!prof.sys_osc && !prof.per);
   end
endmodule

// File: rtl/sleep_wake_select.sv
module sleep_wake_select #(
   parameter int N = 5
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] sel,
   output logic         any
);
   logic [N:0] below;

   assign below[0] = 1'b0;
   generate
      for (genvar i = 0; i < N; i++) begin : g_pri
         assign sel[i]     = req[i] & ~below[i];
         assign below[i+1] = below[i] | req[i];
      end
   endgenerate
   assign any = below[N];

   always_comb begin
      assert_sel_onehot_R11: assert (any ? ($countones(sel) == 1) : (sel == '0));
   end
endmodule

// File: rtl/sleep_osc_timer.sv
module sleep_osc_timer #(
   parameter int CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic done
);
   localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

   generate
      if (CYCLES < 1) begin : g_bad
         $error("sleep_osc_timer: CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   assign done = busy_q && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (start) begin
         cnt_q  <= LOAD;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q <= LOAD));
   assert_done_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !busy_q);
endmodule

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl
   import sleep_pkg::*;
#(
   parameter int OSC_READY_CYCLES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_sel,
   input  logic              sleep_en,
   input  logic              sleep_strobe,
   input  logic              rtc_enable,
   input  logic [4:0]        irq,
   output logic              cpu_clk_en,
   output logic              nvm_clk_en,
   output logic              per_clk_en,
   output logic              rtc_clk_en,
   output logic              sys_osc_en,
   output logic              rtc_osc_en,
   output logic              asleep,
   output logic              wake_pulse,
   output logic [4:0]        wake_src
);
   generate
      if (MODE_W != 3 || WAKE_N != 5) begin : g_bad_pkg
         $error("sleep_clk_ctrl: port widths do not match package");
      end
   endgenerate

   pm_state_t         state_q;
   logic [MODE_W-1:0] mode_q;
   dom_t              prof;
   dom_t              dom;
   logic [WAKE_N-1:0] wake_mask;
   logic [WAKE_N-1:0] win_sel;
   logic              win_any;
   logic              fast;
   logic              timer_start;
   logic              timer_done;
   logic              wake_now;

   sleep_mode_decode u_dec (
      .mode       (mode_q),
      .rtc_enable (rtc_enable),
      .prof       (prof),
      .wake_mask  (wake_mask),
      .fast       (fast)
   );

   sleep_wake_select #(.N(WAKE_N)) u_sel (
      .req (irq & wake_mask),
      .sel (win_sel),
      .any (win_any)
   );

   assign wake_now    = (state_q == ST_SLEEP) && win_any;
   assign timer_start = wake_now && !fast;

   sleep_osc_timer #(.CYCLES(OSC_READY_CYCLES)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (timer_start),
      .done  (timer_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_ACTIVE;
         mode_q     <= MODE_IDLE;
         wake_pulse <= 1'b0;
         wake_src   <= '0;
      end else begin
         wake_pulse <= 1'b0;
         wake_src   <= '0;
         case (state_q)
            ST_ACTIVE: if (sleep_strobe && sleep_en) begin
               state_q <= ST_SLEEP;
               mode_q  <= mode_sel;
            end
            ST_SLEEP: if (win_any) begin
               wake_pulse <= 1'b1;
               wake_src   <= win_sel;
               state_q    <= fast ? ST_ACTIVE : ST_WARM;
            end
            ST_WARM: if (timer_done) state_q <= ST_ACTIVE;
            default: state_q <= ST_ACTIVE;
         endcase
      end
   end

   always_comb begin
      case (state_q)
         ST_SLEEP: dom = prof;
         ST_WARM: begin
            dom         = prof;
            dom.sys_osc = 1'b1;
         end
         default: dom = '{cpu: 1'b1, nvm: 1'b1, per: 1'b1, rtc: rtc_enable,
                          sys_osc: 1'b1, rtc_osc: rtc_enable};
      endcase
   end

   assign cpu_clk_en = dom.cpu;
   assign nvm_clk_en = dom.nvm;
   assign per_clk_en = dom.per;
   assign rtc_clk_en = dom.rtc;
   assign sys_osc_en = dom.sys_osc;
   assign rtc_osc_en = dom.rtc_osc;
   assign asleep     = (state_q != ST_ACTIVE);

   assert_strobe_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!asleep && sleep_strobe && !sleep_en) |=> (!asleep && cpu_clk_en));
   assert_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!asleep && sleep_strobe && sleep_en) |=> (asleep && !cpu_clk_en));
   assert_fast_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_pulse && fast) |-> (cpu_clk_en && per_clk_en && !asleep));
   assert_slow_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_pulse && !fast) |-> (!cpu_clk_en && sys_osc_en));
   assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);
   assert_src_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !wake_pulse |-> (wake_src == '0));
   assert_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep && !cpu_clk_en && ((irq & wake_mask) == '0) && !timer_done)
      |=> (asleep && $stable(wake_mask)));
endmodule

// File: tb/sim_sleep_clk_ctrl.sv
module sim_sleep_clk_ctrl;
   localparam int NRDY = 16;
   localparam int NV   = 11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode_sel = 3'd0;
   logic       sleep_en = 1'b0;
   logic       sleep_strobe = 1'b0;
   logic       rtc_enable = 1'b1;
   logic [4:0] irq = 5'd0;
   logic       cpu_clk_en, nvm_clk_en, per_clk_en, rtc_clk_en, sys_osc_en, rtc_osc_en;
   logic       asleep, wake_pulse;
   logic [4:0] wake_src;

   int checks = 0;
   int errors = 0;

   always #4ns clk = ~clk;

   sleep_clk_ctrl #(.OSC_READY_CYCLES(NRDY)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sleep_en(sleep_en),
      .sleep_strobe(sleep_strobe), .rtc_enable(rtc_enable), .irq(irq),
      .cpu_clk_en(cpu_clk_en), .nvm_clk_en(nvm_clk_en), .per_clk_en(per_clk_en),
      .rtc_clk_en(rtc_clk_en), .sys_osc_en(sys_osc_en), .rtc_osc_en(rtc_osc_en),
      .asleep(asleep), .wake_pulse(wake_pulse), .wake_src(wake_src)
   );

   wire [5:0] en_vec = {cpu_clk_en, nvm_clk_en, per_clk_en, rtc_clk_en, sys_osc_en, rtc_osc_en};

   // mode, rtc_enable, wake irq, ignored irq, enables {cpu,nvm,per,rtc,sys,rtco}, src, slow
   localparam logic [25:0] VEC [NV] = '{
      {3'd0, 1'b1, 5'b10000, 5'b00000, 6'b001111, 5'b10000, 1'b0}, // R4 idle
      {3'd0, 1'b0, 5'b10100, 5'b00000, 6'b001010, 5'b00100, 1'b0}, // R4 idle, two sources
      {3'd2, 1'b1, 5'b00010, 5'b11100, 6'b000000, 5'b00010, 1'b1}, // R5 power-down
      {3'd3, 1'b1, 5'b01000, 5'b10000, 6'b000101, 5'b01000, 1'b1}, // R6 power-save
      {3'd3, 1'b0, 5'b00011, 5'b10000, 6'b000000, 5'b00001, 1'b1}, // R6 rtc off
      {3'd6, 1'b1, 5'b00001, 5'b11100, 6'b000010, 5'b00001, 1'b0}, // R7 standby
      {3'd7, 1'b1, 5'b00100, 5'b10000, 6'b000111, 5'b00100, 1'b0}, // R8 ext standby
      {3'd7, 1'b0, 5'b01010, 5'b10000, 6'b000010, 5'b00010, 1'b0}, // R8 rtc off
      {3'd1, 1'b1, 5'b10000, 5'b00000, 6'b001111, 5'b10000, 1'b0}, // R3 reserved 1
      {3'd5, 1'b0, 5'b01000, 5'b00000, 6'b001010, 5'b01000, 1'b0}, // R3 reserved 5
      {3'd4, 1'b1, 5'b00001, 5'b00000, 6'b001111, 5'b00001, 1'b0}  // R3 reserved 4
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic string mtag(input logic [2:0] m);
      case (m)
         3'd0: return "R4";
         3'd2: return "R5";
         3'd3: return "R6";
         3'd6: return "R7";
         3'd7: return "R8";
         default: return "R3";
      endcase
   endfunction

   function automatic logic [5:0] active_en(input logic r);
      return {1'b1, 1'b1, 1'b1, r, 1'b1, r};
   endfunction

   task automatic enter(input logic [2:0] m);
      mode_sel     = m;
      sleep_en     = 1'b1;
      sleep_strobe = 1'b1;
      @(negedge clk);
      sleep_strobe = 1'b0;
   endtask

   task automatic run_vec(input int i);
      logic [25:0] v;
      v = VEC[i];
      rtc_enable = v[22];
      enter(v[25:23]);
      chk("R2 asleep", 32'(asleep), 32'd1);
      chk(mtag(v[25:23]), 32'(en_vec), 32'(v[11:6]));
      mode_sel = ~v[25:23];
      if (v[16:12] != 5'd0) begin
         irq = v[16:12];
         @(negedge clk);
         chk("R12 stay", 32'(asleep), 32'd1);
         chk("R12 pulse", 32'(wake_pulse), 32'd0);
         chk("R12 en", 32'(en_vec), 32'(v[11:6]));
      end
      @(negedge clk);
      chk("R2 latched", 32'(en_vec), 32'(v[11:6]));
      irq = v[21:17];
      @(negedge clk);
      irq = 5'd0;
      chk("R11 pulse", 32'(wake_pulse), 32'd1);
      chk("R11 src", 32'(wake_src), 32'(v[5:1]));
      if (v[0]) begin
         chk("R9 osc", 32'(sys_osc_en), 32'd1);
         chk("R9 cpu off", 32'(cpu_clk_en), 32'd0);
         repeat (NRDY - 1) @(negedge clk);
         chk("R9 still off", 32'(cpu_clk_en), 32'd0);
         chk("R11 single", 32'(wake_pulse), 32'd0);
         @(negedge clk);
         chk("R9 ready", 32'(en_vec), 32'(active_en(v[22])));
      end else begin
         chk("R10 fast", 32'(en_vec), 32'(active_en(v[22])));
         chk("R10 awake", 32'(asleep), 32'd0);
         @(negedge clk);
         chk("R11 single", 32'(wake_pulse), 32'd0);
         chk("R11 src clear", 32'(wake_src), 32'd0);
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 en in reset", 32'(en_vec), 32'(active_en(1'b1)));
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 en", 32'(en_vec), 32'(active_en(1'b1)));
      chk("R1 asleep", 32'(asleep), 32'd0);
      chk("R1 pulse", 32'({wake_pulse, wake_src}), 32'd0);
      rtc_enable = 1'b0;
      @(negedge clk);
      chk("R1 rtc follow", 32'(en_vec), 32'(active_en(1'b0)));

      // strobe without enable is ignored
      mode_sel = 3'd2; sleep_en = 1'b0; sleep_strobe = 1'b1;
      @(negedge clk);
      sleep_strobe = 1'b0;
      chk("R2 ignored", 32'(asleep), 32'd0);
      chk("R2 ignored en", 32'(en_vec), 32'(active_en(1'b0)));
      @(negedge clk);

      for (int i = 0; i < NV; i++) run_vec(i);

      // strobe and wake interrupt in the same cycle
      rtc_enable = 1'b1;
      mode_sel = 3'd0; sleep_en = 1'b1; sleep_strobe = 1'b1; irq = 5'b10000;
      @(negedge clk);
      sleep_strobe = 1'b0;
      chk("R2 same-cycle entry", 32'(asleep), 32'd1);
      chk("R11 no early pulse", 32'(wake_pulse), 32'd0);
      @(negedge clk);
      irq = 5'd0;
      chk("R11 same-cycle pulse", 32'({wake_pulse, wake_src}), 32'b110000);
      chk("R10 same-cycle awake", 32'(asleep), 32'd0);
      @(negedge clk);

      // reset during power-down sleep
      enter(3'd2);
      chk("R13 asleep", 32'(asleep), 32'd1);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R13 en", 32'(en_vec), 32'(active_en(1'b1)));
      chk("R13 awake", 32'(asleep), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // reset during oscillator warm-up
      enter(3'd3);
      irq = 5'b00001;
      @(negedge clk);
      irq = 5'd0;
      @(negedge clk);
      chk("R9 warming", 32'(cpu_clk_en), 32'd0);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R13 warm reset", 32'(en_vec), 32'(active_en(1'b1)));
      rst_n = 1'b1;
      @(negedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1200us;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule